// File: doc/BRIEF.md
# Asynchronous Parallel ROM Read Controller

This block sits between a synchronous host and an external byte-wide read-only memory that has no clock. The memory has a 20-bit address bus, an 8-bit data bus and two active-low enables: a chip enable and an output enable. The memory drives its data pins only while both enables are low. While the chip enable is high, its outputs float no matter what the output enable is doing.

The host raises `req` with an address and a speed-grade code. The controller waits until it may start a new access. It then drives the address, pulls the chip enable low, and pulls the output enable low one cycle later. It counts down three separate access windows, one each for address, chip enable and output enable. It samples the data bus once the last of the three has expired. The byte goes back to the host on `rdata` with a one-cycle `rvalid`. At that same edge both enables are released.

Before the next access, the controller waits out a float-recovery gap and a minimum cycle time. Every window in the memory's timing is converted to clock cycles: the time is rounded up to whole clock periods and one sampling cycle is added.

Top module: `romReadCtl`

## Requirements
- R1: After reset `romCeN` and `romOeN` are high, and `rvalid` and `busy` are low.
- R2: A request is accepted at a rising edge where `req` is high and `busy` is low. At that edge `romAddr` takes `addr` and `romCeN` goes low. In the following cycle `busy` is high.
- R3: `romOeN` goes low exactly one cycle after `romCeN` goes low.
- R4: With the window count for a time t defined as N(t) = ceil(t / clock period) + 1, the data bus is sampled at the edge max(N(tAddr), N(tCe), 1 + N(tOe)) cycles after the accepting edge. At that edge `rdata` takes the bus value and `rvalid` is high for exactly one cycle.
- R5: The `grade` code selects the timing. Code 0 is fast: address, chip-enable and cycle time are 100 ns, output-enable is 50 ns and float is 20 ns. Code 1 is medium: 120, 60 and 20 ns. Code 2 is slow: 150, 70 and 30 ns. Code 3 behaves as code 2.
- R6: Both enables rise at the sampling edge.
- R7: No request is accepted earlier than N(tFloat) cycles after the previous sampling edge. tFloat is the float time of the previous read's grade.
- R8: No request is accepted earlier than N(tCycle) cycles after the previous accepting edge.
- R9: A request made while `busy` is high is not lost. If `req` stays high, it is accepted at the first edge where `busy` is low.
- R10: `romAddr` holds its value from one accepting edge to the next, so data is always taken before the address moves.
- R11: The grade is captured at the accepting edge. A change on `grade` during an access does not change that access's sampling or float timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, held high until accepted |
| addr | input | 20 | Byte address for the request |
| grade | input | 2 | Speed-grade code (0 fast, 1 medium, 2 and 3 slow) |
| busy | output | 1 | High while a request cannot be accepted |
| rdata | output | 8 | Byte read from the memory |
| rvalid | output | 1 | One-cycle strobe qualifying `rdata` |
| romAddr | output | 20 | Address to the memory |
| romCeN | output | 1 | Active-low chip enable to the memory |
| romOeN | output | 1 | Active-low output enable to the memory |
| romData | input | 8 | Data bus from the memory |

## Verification
Each read has its acceptance edge predicted from the previous read's sampling edge plus the float count, and from its acceptance plus the cycle-time count. From that edge, `romCeN` is due low one cycle later, `romOeN` two cycles later, and `rvalid` after the largest of the three access counts. A scoreboard entry stores the predicted byte and the predicted cycle. The monitor samples at the falling edge and compares both, so a read that arrives one cycle early or one cycle late is counted as a miscompare. The memory model in the bench puts a wrong byte on the bus whenever an access window has not truly elapsed. It also counts any enable that falls inside the float gap.

// File: rtl/romrd_pkg.sv
package romrd_pkg;

  localparam int NUM_PATHS = 5;
  localparam int PATH_AA   = 0;
  localparam int PATH_CE   = 1;
  localparam int PATH_OE   = 2;
  localparam int PATH_RC   = 3;
  localparam int PATH_DF   = 4;

  typedef struct packed {
    logic load;
    logic capture;
  } dpStrobe_t;

  // window length in ns for a timing path and grade code (3 folds onto slow)
  function automatic int pathNs(int path, logic [1:0] grade);
    int g;
    g = (grade == 2'd3) ? 2 : int'(grade);
    case (path)
      PATH_OE: return (g == 0) ? 50 : (g == 1) ? 60 : 70;
      PATH_DF: return (g == 2) ? 30 : 20;
      default: return (g == 0) ? 100 : (g == 1) ? 120 : 150;
    endcase
  endfunction

  // whole clock periods covering the window plus one sampling cycle
  function automatic int cyclesFor(int ns, int periodPs);
    return (ns * 1000 + periodPs - 1) / periodPs + 1;
  endfunction

endpackage

// File: rtl/romrd_timer.sv
module romrd_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] loadVal,
  output logic             expired
);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (start)         count <= loadVal;
    else if (count != '0)   count <= count - 1'b1;
  end

  assign expired = (count == '0);

endmodule

// File: rtl/romrd_ctrl.sv
module romrd_ctrl
  import romrd_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int CNT_W         = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic [1:0] grade,
  output logic       busy,
  output logic       ceN,
  output logic       oeN,
  output dpStrobe_t  strobe
);

  typedef enum logic {S_IDLE, S_ACCESS} state_t;

  state_t                 state;
  logic [1:0]             gradeQ;
  logic                   accept;
  logic                   capture;
  logic [NUM_PATHS-1:0]   pathStart;
  logic [NUM_PATHS-1:0]   pathDone;
  logic [CNT_W-1:0]       pathLoad [NUM_PATHS];

  // OE window is measured from one cycle after acceptance, so it loads one more
  always_comb begin
    for (int p = 0; p < NUM_PATHS; p++) begin
      pathLoad[p] = CNT_W'(cyclesFor(pathNs(p, (p == PATH_DF) ? gradeQ : grade),
                                     CLK_PERIOD_PS) - ((p == PATH_OE) ? 0 : 1));
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PATHS; gp++) begin : g_path
      assign pathStart[gp] = (gp == PATH_DF) ? capture : accept;
      romrd_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rstN    (rstN),
        .start   (pathStart[gp]),
        .loadVal (pathLoad[gp]),
        .expired (pathDone[gp])
      );
    end
  endgenerate

  assign busy    = (state != S_IDLE) || !pathDone[PATH_RC] || !pathDone[PATH_DF];
  assign accept  = req && !busy;
  assign capture = (state == S_ACCESS) && pathDone[PATH_AA] &&
                   pathDone[PATH_CE] && pathDone[PATH_OE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      gradeQ <= 2'd0;
      ceN    <= 1'b1;
      oeN    <= 1'b1;
    end else if (accept) begin
      state  <= S_ACCESS;
      gradeQ <= grade;
      ceN    <= 1'b0;
    end else if (capture) begin
      state  <= S_IDLE;
      ceN    <= 1'b1;
      oeN    <= 1'b1;
    end else if (state == S_ACCESS) begin
      oeN    <= 1'b0;
    end
  end

  assign strobe.load    = accept;
  assign strobe.capture = capture;

  // cycles since the last capture and the float count it required, for R7
  logic [CNT_W-1:0] sinceCap;
  logic [CNT_W-1:0] dfNeed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceCap <= '1;
      dfNeed   <= '0;
    end else if (capture) begin
      sinceCap <= CNT_W'(1);
      dfNeed   <= pathLoad[PATH_DF] + 1'b1;
    end else if (sinceCap != '1) begin
      sinceCap <= sinceCap + 1'b1;
    end
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (busy && !ceN));
  a_r3_oe_follows_ce: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ceN) |=> $fell(oeN));
  a_r6_enables_release: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> (ceN && oeN));
  a_r7_float_gap: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (sinceCap >= dfNeed));

endmodule

// File: rtl/romrd_dpath.sv
module romrd_dpath
  import romrd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romAddr <= '0;
      rdata   <= '0;
      rvalid  <= 1'b0;
    end else begin
      if (strobe.load)    romAddr <= addr;
      if (strobe.capture) rdata   <= romData;
      rvalid <= strobe.capture;
    end
  end

  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(romAddr));
  a_r4_single_valid: assert property (@(posedge clk) disable iff (!rstN)
    rvalid |=> !rvalid);

endmodule

// File: rtl/romReadCtl.sv
module romReadCtl
  import romrd_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        grade,
  output logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  input  logic [DATA_W-1:0] romData
);

  dpStrobe_t strobe;

  romrd_ctrl #(.CLK_PERIOD_PS(CLK_PERIOD_PS), .CNT_W(CNT_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .req    (req),
    .grade  (grade),
    .busy   (busy),
    .ceN    (romCeN),
    .oeN    (romOeN),
    .strobe (strobe)
  );

  romrd_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addr    (addr),
    .romData (romData),
    .romAddr (romAddr),
    .rdata   (rdata),
    .rvalid  (rvalid)
  );

endmodule

// File: tb/romReadCtl_tb_top.sv
module romReadCtl_tb_top;

  localparam int PER_PS = 4000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic [19:0] addr = '0;
  logic [1:0]  grade = 2'd0;
  logic        busy, rvalid, romCeN, romOeN;
  logic [7:0]  rdata, romData;
  logic [19:0] romAddr;

  romReadCtl dut_i (
    .clk(clk), .rstN(rstN), .req(req), .addr(addr), .grade(grade),
    .busy(busy), .rdata(rdata), .rvalid(rvalid), .romAddr(romAddr),
    .romCeN(romCeN), .romOeN(romOeN), .romData(romData)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic check(bit ok, string rq, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, expv, cyc);
    end
  endtask

  // timing tables written from the requirements: kind 0 addr/ce/cycle, 1 oe, 2 float
  function automatic int tNs(int kind, int g);
    int s;
    s = (g == 3) ? 2 : g;
    if (kind == 1) return (s == 0) ? 50 : (s == 1) ? 60 : 70;
    if (kind == 2) return (s == 2) ? 30 : 20;
    return (s == 0) ? 100 : (s == 1) ? 120 : 150;
  endfunction
  function automatic int rawCyc(int ns);
    return (ns * 1000 + PER_PS - 1) / PER_PS;
  endfunction
  function automatic int nCyc(int ns);
    return rawCyc(ns) + 1;
  endfunction
  function automatic logic [7:0] romByte(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  // memory model: wrong byte unless every window has truly elapsed
  int   modelGrade = 0;
  int   addrCyc = -1000, ceCyc = -1000, oeCyc = -1000, ceUpCyc = -1000;
  int   dfNeedRaw = 0, floatViol = 0;
  logic [19:0] lastAddr = '0;
  logic ceWas = 1'b1, oeWas = 1'b1;
  logic [7:0] romDrv = 8'hEE;
  assign romData = romDrv;

  always @(negedge clk) begin
    if (romAddr != lastAddr) begin addrCyc = cyc; lastAddr = romAddr; end
    if (!romCeN && ceWas) begin
      if (cyc - ceUpCyc < dfNeedRaw) floatViol++;
      ceCyc = cyc;
    end
    if (romCeN && !ceWas) begin
      ceUpCyc = cyc;
      dfNeedRaw = rawCyc(tNs(2, modelGrade));
    end
    if (!romOeN && oeWas) oeCyc = cyc;
    ceWas = romCeN;
    oeWas = romOeN;
    if (!romCeN && !romOeN &&
        (cyc + 1 - addrCyc) >= rawCyc(tNs(0, modelGrade)) &&
        (cyc + 1 - ceCyc)   >= rawCyc(tNs(0, modelGrade)) &&
        (cyc + 1 - oeCyc)   >= rawCyc(tNs(1, modelGrade)))
      romDrv = romByte(romAddr);
    else
      romDrv = 8'hEE;
  end

  typedef struct { logic [7:0] data; logic [19:0] a; int due; } exp_t;
  exp_t sb[$];

  // monitor: pops and compares every returned byte
  always @(negedge clk) begin
    if (rstN && rvalid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4 unexpected rvalid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rdata == e.data, "R4 data", rdata, e.data);
        check(cyc == e.due, "R4 R5 sampling cycle", cyc, e.due);
        check(romCeN && romOeN, "R6 enables high at capture", {romCeN, romOeN}, 3);
        check(romAddr == e.a, "R10 address held", romAddr, e.a);
      end
    end
  end

  int prevDue = -1000, prevAcc = -1000, prevGrade = 0;

  // driver: holds req until accepted, predicts timing and pushes the result
  task automatic doRead(logic [19:0] a, int g, int gAfter);
    int reqCyc, acc, expAcc, d;
    exp_t e;
    @(negedge clk);
    req = 1'b1; addr = a; grade = 2'(g);
    reqCyc = cyc + 1;
    while (busy) @(negedge clk);
    acc = cyc + 1;
    modelGrade = g;
    expAcc = reqCyc;
    if (prevDue + nCyc(tNs(2, prevGrade)) > expAcc) expAcc = prevDue + nCyc(tNs(2, prevGrade));
    if (prevAcc + nCyc(tNs(0, prevGrade)) > expAcc) expAcc = prevAcc + nCyc(tNs(0, prevGrade));
    check(acc == expAcc, "R7 R8 R9 accept cycle", acc, expAcc);
    check(acc >= prevAcc + nCyc(tNs(0, prevGrade)), "R8 cycle time", acc, prevAcc);
    d = nCyc(tNs(0, g));
    if (1 + nCyc(tNs(1, g)) > d) d = 1 + nCyc(tNs(1, g));
    e.data = romByte(a); e.a = a; e.due = acc + d;
    sb.push_back(e);
    prevDue = e.due; prevAcc = acc; prevGrade = g;
    @(negedge clk);
    check(romAddr == a, "R2 address driven", romAddr, a);
    check(!romCeN && romOeN, "R2 R3 ce low, oe still high", {romCeN, romOeN}, 1);
    check(busy, "R2 busy after accept", busy, 1);
    req = 1'b0;
    grade = 2'(gAfter);     // R11: late grade change must not matter
    @(negedge clk);
    check(!romOeN, "R3 oe low one cycle later", romOeN, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(romCeN && romOeN, "R1 enables idle", {romCeN, romOeN}, 3);
    check(!rvalid && !busy, "R1 rvalid busy low", {rvalid, busy}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy, "R1 busy low after reset", busy, 0);
    doRead(20'h00000, 0, 0);
    doRead(20'hFFFFF, 0, 0);
    doRead(20'h12345, 1, 1);
    doRead(20'hABCDE, 2, 2);
    doRead(20'h0F0F0, 3, 3);
    doRead(20'h54321, 0, 2);   // R11 grade raised mid-access
    doRead(20'h80001, 2, 0);   // R11 grade lowered mid-access
    doRead(20'h7FFFE, 1, 3);
    repeat (60) @(negedge clk);
    doRead(20'h3C3C3, 2, 2);   // R5 start from idle
    doRead(20'h3C3C4, 0, 0);   // R7 slow float gap before a fast read
    wait (sb.size() == 0);
    repeat (20) @(negedge clk);
    check(floatViol == 0, "R7 enable fell inside float gap", floatViol, 0);
    check(!busy && romCeN && romOeN, "R6 idle after last read", {busy, romCeN, romOeN}, 3);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule